// File: doc/BRIEF.md
# Up-Counting Timer with Buffered Reload

This block is a general-purpose timer whose counter climbs by one on every clock while it runs. After it reaches the active reload value it returns to zero, and that return counts as an overflow. A small single-cycle register bus lets software start and stop the counter and poll a running flag. The same bus sets the reload value and chooses how update events are formed.

A reload value can be written straight to the active copy, or written to a waiting copy that moves into the active copy only on an update event. An update event comes from an overflow, or from a software trigger that also clears the counter. Two control bits gate it: one disables update events outright, and one limits them to overflows only. Each update event sets a sticky flag, and software clears that flag by writing one. The interrupt line is the flag gated by an enable bit.

Register offsets: 0x00 command/status, 0x04 control, 0x08 interrupt enable, 0x0C flag, 0x10 software trigger, 0x14 counter (read-only), 0x18 reload.

Top module: `uptimer_preload`

## Requirements
- R1: After reset every register reads zero, except the reload register, which reads 2^CNT_W-1. The interrupt output is low.
- R2: Control register (0x04): bit 4 buffers reload writes, bit 2 limits update events to overflows, bit 1 disables update events. Interrupt enable register (0x08): bit 0. All other bits of both registers read as zero.
- R3: At 0x00, writing bit 0 as 1 starts the counter and writing bit 1 as 1 stops it. Stop wins when both bits are 1. Zeros in those bits have no effect.
- R4: Read bit 2 of 0x00 is the running status. It changes exactly one clock after the start or stop write is taken. The counter holds its value while the status is 0.
- R5: While running, the counter goes up by one per clock. In the count after it equals the active reload value it goes to zero, and that step is an overflow. The period is therefore reload+1 clocks.
- R6: With buffering off, a reload write takes effect at once. With buffering on, it changes only the waiting copy, which moves to the active copy on an update event. Reading 0x18 returns the last written value.
- R7: With update events disabled, overflows still wrap the counter, but the active reload does not change and the flag is not set.
- R8: Writing 1 to bit 0 of 0x10 always clears the counter, and that bit reads as 0. It causes an update event only when events are enabled and not limited to overflows.
- R9: Bit 0 of 0x0C is set by every update event and cleared by writing 1 to it. If a clear and an update event fall in the same cycle, the set wins.
- R10: The interrupt output equals the flag ANDed with the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| irq | output | 1 | Update interrupt |

## Verification
A counter overflow, which sets the flag, can occur in the same cycle as a software write that clears the flag. The bench provokes this by starting a short period and counting clocks from the start write. It then times the flag-clear write so that the write is taken on the exact edge where the counter wraps. The flag must read 1 afterwards, and the counter must read 0. A clear made away from any overflow must still drop the flag.

// File: rtl/uptimer_pkg.sv
package uptimer_pkg;

  // register byte offsets
  localparam int unsigned OFS_CMD  = 'h00;
  localparam int unsigned OFS_CTRL = 'h04;
  localparam int unsigned OFS_IEN  = 'h08;
  localparam int unsigned OFS_FLAG = 'h0C;
  localparam int unsigned OFS_TRIG = 'h10;
  localparam int unsigned OFS_CNT  = 'h14;
  localparam int unsigned OFS_RLD  = 'h18;

  // bit positions
  localparam int unsigned B_START = 0;
  localparam int unsigned B_STOP  = 1;
  localparam int unsigned B_RUN   = 2;
  localparam int unsigned B_BUF   = 4;
  localparam int unsigned B_OVFO  = 2;
  localparam int unsigned B_DIS   = 1;

  // the counter has reached its limit
  function automatic logic at_limit(input logic [31:0] cnt, input logic [31:0] lim);
    return cnt == lim;
  endfunction

  // an update event is formed from overflow or software trigger
  function automatic logic update_fires(input logic ovf, input logic trig,
                                        input logic dis, input logic ovf_only);
    return !dis && (ovf || (trig && !ovf_only));
  endfunction

endpackage

// File: rtl/uptimer_regs.sv
module uptimer_regs
  import uptimer_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  rld_wait,
  input  logic              uev,
  output logic              buf_en,
  output logic              ovf_only,
  output logic              upd_dis,
  output logic              ien,
  output logic              trig,
  output logic              rld_wr,
  output logic              run_q,
  output logic              cmd_start,
  output logic              cmd_stop,
  output logic              flag,
  output logic              flag_clr,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(OFS_IEN);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(OFS_FLAG);
  localparam logic [ADDR_W-1:0] A_TRIG = ADDR_W'(OFS_TRIG);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_CNT);
  localparam logic [ADDR_W-1:0] A_RLD  = ADDR_W'(OFS_RLD);

  logic wr;
  logic run_req;

  assign wr        = sel && we;
  assign cmd_start = wr && (addr == A_CMD) && wdata[B_START];
  assign cmd_stop  = wr && (addr == A_CMD) && wdata[B_STOP];
  assign trig      = wr && (addr == A_TRIG) && wdata[0];
  assign rld_wr    = wr && (addr == A_RLD);
  assign flag_clr  = wr && (addr == A_FLAG) && wdata[0];
  assign irq       = flag && ien;

  // command request, then one-cycle delayed running status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_req <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      if (cmd_stop)       run_req <= 1'b0;
      else if (cmd_start) run_req <= 1'b1;
      run_q <= run_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_en   <= 1'b0;
      ovf_only <= 1'b0;
      upd_dis  <= 1'b0;
      ien      <= 1'b0;
    end else begin
      if (wr && addr == A_CTRL) begin
        buf_en   <= wdata[B_BUF];
        ovf_only <= wdata[B_OVFO];
        upd_dis  <= wdata[B_DIS];
      end
      if (wr && addr == A_IEN) ien <= wdata[0];
    end
  end

  // sticky flag: set has priority over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (uev)      flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CMD:   rdata[B_RUN] = run_q;
      A_CTRL: begin
        rdata[B_BUF]  = buf_en;
        rdata[B_OVFO] = ovf_only;
        rdata[B_DIS]  = upd_dis;
      end
      A_IEN:   rdata[0] = ien;
      A_FLAG:  rdata[0] = flag;
      A_CNT:   rdata = DATA_W'(cnt);
      A_RLD:   rdata = DATA_W'(rld_wait);
      default: rdata = '0;
    endcase
  end

  generate
    if (DATA_W > 8) begin : g_unused
      logic unused_wdata;
      assign unused_wdata = ^wdata[DATA_W-1:8];
    end
  endgenerate

endmodule

// File: rtl/uptimer_reload.sv
module uptimer_reload #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rld_wr,
  input  logic [CNT_W-1:0] rld_data,
  input  logic             buf_en,
  input  logic             uev,
  output logic [CNT_W-1:0] rld_wait,
  output logic [CNT_W-1:0] rld_act
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_wait <= '1;
      rld_act  <= '1;
    end else begin
      if (rld_wr) rld_wait <= rld_data;
      if (rld_wr && !buf_en) rld_act <= rld_data;
      else if (uev)          rld_act <= rld_wait;
    end
  end
endmodule

// File: rtl/uptimer_counter.sv
module uptimer_counter
  import uptimer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             trig,
  input  logic             upd_dis,
  input  logic             ovf_only,
  input  logic [CNT_W-1:0] rld_act,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf,
  output logic             uev
);
  assign ovf = run && at_limit(32'(cnt), 32'(rld_act));
  assign uev = update_fires(ovf, trig, upd_dis, ovf_only);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (trig) cnt <= '0;
    else if (run)  cnt <= ovf ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/uptimer_preload.sv
module uptimer_preload #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [CNT_W-1:0] cnt, rld_wait, rld_act;
  logic buf_en, ovf_only, upd_dis, ien, trig, rld_wr;
  logic run_q, cmd_start, cmd_stop, flag, flag_clr, ovf, uev;

  uptimer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .cnt(cnt), .rld_wait(rld_wait),
    .uev(uev), .buf_en(buf_en), .ovf_only(ovf_only), .upd_dis(upd_dis),
    .ien(ien), .trig(trig), .rld_wr(rld_wr), .run_q(run_q),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .flag(flag),
    .flag_clr(flag_clr), .irq(irq)
  );

  uptimer_reload #(.CNT_W(CNT_W)) reload_i (
    .clk(clk), .rst_n(rst_n), .rld_wr(rld_wr), .rld_data(bus_wdata[CNT_W-1:0]),
    .buf_en(buf_en), .uev(uev), .rld_wait(rld_wait), .rld_act(rld_act)
  );

  uptimer_counter #(.CNT_W(CNT_W)) counter_i (
    .clk(clk), .rst_n(rst_n), .run(run_q), .trig(trig), .upd_dis(upd_dis),
    .ovf_only(ovf_only), .rld_act(rld_act), .cnt(cnt), .ovf(ovf), .uev(uev)
  );
endmodule

// File: rtl/uptimer_checker.sv
module uptimer_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             cmd_start,
  input logic             cmd_stop,
  input logic [CNT_W-1:0] cnt,
  input logic             ovf,
  input logic             trig,
  input logic             uev,
  input logic             flag,
  input logic             flag_clr,
  input logic             ien,
  input logic             irq,
  input logic             buf_en,
  input logic             upd_dis,
  input logic             rld_wr,
  input logic [CNT_W-1:0] rld_act
);
  assert_start_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && !cmd_stop) ##1 !cmd_stop |=> run);
  assert_stop_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop ##1 !cmd_start |=> !run);
  assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !trig |=> $stable(cnt));
  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run && !trig && !ovf |=> cnt == CNT_W'($past(cnt) + 1'b1));
  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !trig |=> cnt == '0);
  assert_trig_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> cnt == '0);
  assert_buffer_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_en && !uev |=> $stable(rld_act));
  assert_disable_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_dis && !(rld_wr && !buf_en) |=> $stable(rld_act));
  assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    uev |=> flag);
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !flag_clr |=> flag);
  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |-> !irq);
endmodule

bind uptimer_preload uptimer_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .run(run_q), .cmd_start(cmd_start),
  .cmd_stop(cmd_stop), .cnt(cnt), .ovf(ovf), .trig(trig), .uev(uev),
  .flag(flag), .flag_clr(flag_clr), .ien(ien), .irq(irq), .buf_en(buf_en),
  .upd_dis(upd_dis), .rld_wr(rld_wr), .rld_act(rld_act)
);

// File: tb/uptimer_preload_tb.sv
module uptimer_preload_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;

  localparam logic [ADDR_W-1:0] A_CMD = 5'h00, A_CTRL = 5'h04, A_IEN = 5'h08,
    A_FLAG = 5'h0C, A_TRIG = 5'h10, A_CNT = 5'h14, A_RLD = 5'h18;

  // {reload, clocks run}
  localparam int VEC [0:5][0:1] = '{
    '{3, 2}, '{3, 9}, '{5, 5}, '{5, 6}, '{0, 4}, '{10, 30}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic irq;
  int checks = 0;
  int errors = 0;
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  uptimer_preload #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic int exp_count(input int rld, input int n);
    return n % (rld + 1);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rdreg(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // stopped counter at zero, flag clear, given reload active
  task automatic prime(input int rld);
    wr(A_CTRL, 32'h0);
    wr(A_RLD, rld);
    wr(A_TRIG, 32'h1);
    wr(A_FLAG, 32'h1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    waitn(3);
    rst_n = 1'b1;
    waitn(1);

    // R1 reset values
    rdreg(A_CMD, rd);  check("R1 cmd", rd, 0);
    rdreg(A_CTRL, rd); check("R1 ctrl", rd, 0);
    rdreg(A_IEN, rd);  check("R1 ien", rd, 0);
    rdreg(A_FLAG, rd); check("R1 flag", rd, 0);
    rdreg(A_CNT, rd);  check("R1 cnt", rd, 0);
    rdreg(A_RLD, rd);  check("R1 reload", rd, 32'hFFFF);
    check("R1 irq", irq, 0);

    // R2 reserved bits
    wr(A_CTRL, 32'hFFFF_FFFF);
    rdreg(A_CTRL, rd); check("R2 ctrl mask", rd, 32'h16);
    wr(A_IEN, 32'hFFFF_FFFF);
    rdreg(A_IEN, rd);  check("R2 ien mask", rd, 32'h1);
    wr(A_IEN, 32'h0);
    wr(A_CTRL, 32'h0);

    // R4 status delay, R3 commands
    wr(A_CMD, 32'h1);
    rdreg(A_CMD, rd); check("R4 status before", rd, 0);
    waitn(1);
    rdreg(A_CMD, rd); check("R4 status after", rd, 32'h4);
    wr(A_CMD, 32'h0);
    waitn(2);
    rdreg(A_CMD, rd); check("R3 zero write ignored", rd, 32'h4);
    wr(A_CMD, 32'h3);
    waitn(1);
    rdreg(A_CMD, rd); check("R3 stop wins", rd, 0);
    rdreg(A_CNT, rd);
    waitn(3);
    begin
      logic [31:0] rd2;
      rdreg(A_CNT, rd2); check("R4 frozen", rd2, rd);
    end

    // R5 table walk
    for (int v = 0; v < 6; v++) begin
      int a, n;
      a = VEC[v][0]; n = VEC[v][1];
      prime(a);
      wr(A_CMD, 32'h1);
      waitn(n + 1);
      rdreg(A_CNT, rd);  check("R5 count", rd, exp_count(a, n));
      rdreg(A_FLAG, rd); check("R9 flag by overflow", rd, (n >= a + 1) ? 1 : 0);
      wr(A_CMD, 32'h2);
      waitn(4);
      rdreg(A_CNT, rd);  check("R4 count after stop", rd, exp_count(a, n + 2));
    end

    // R6 buffered reload
    prime(3);
    wr(A_CTRL, 32'h10);
    wr(A_RLD, 7);
    rdreg(A_RLD, rd); check("R6 readback", rd, 7);
    wr(A_CMD, 32'h1);
    waitn(10);
    rdreg(A_CNT, rd); check("R6 buffered swap", rd, 5);
    wr(A_CMD, 32'h2);
    waitn(2);

    // R7 update disabled
    prime(3);
    wr(A_CTRL, 32'h12);
    wr(A_RLD, 7);
    wr(A_CMD, 32'h1);
    waitn(10);
    rdreg(A_CNT, rd);  check("R7 reload kept", rd, 1);
    rdreg(A_FLAG, rd); check("R7 no flag", rd, 0);
    wr(A_CMD, 32'h2);
    waitn(2);

    // R8 software trigger
    rdreg(A_CNT, rd);  check("R8 nonzero before", rd, 3);
    wr(A_CTRL, 32'h04);
    wr(A_TRIG, 32'h1);
    rdreg(A_CNT, rd);  check("R8 trigger clears", rd, 0);
    rdreg(A_FLAG, rd); check("R8 overflow-only no flag", rd, 0);
    rdreg(A_TRIG, rd); check("R8 trigger reads 0", rd, 0);
    wr(A_CTRL, 32'h02);
    wr(A_TRIG, 32'h1);
    rdreg(A_FLAG, rd); check("R8 disabled no flag", rd, 0);
    wr(A_CTRL, 32'h00);
    wr(A_TRIG, 32'h1);
    rdreg(A_FLAG, rd); check("R8 trigger sets flag", rd, 1);

    // R10 interrupt gating
    check("R10 irq masked", irq, 0);
    wr(A_IEN, 32'h1);
    check("R10 irq raised", irq, 1);
    wr(A_FLAG, 32'h1);
    check("R10 irq after clear", irq, 0);
    wr(A_IEN, 32'h0);

    // R9 clear colliding with overflow
    prime(3);
    wr(A_CMD, 32'h1);
    waitn(4);
    rdreg(A_FLAG, rd); check("R9 flag before wrap", rd, 0);
    wr(A_FLAG, 32'h1);
    rdreg(A_FLAG, rd); check("R9 set wins", rd, 1);
    rdreg(A_CNT, rd);  check("R9 wrapped", rd, 0);
    wr(A_CMD, 32'h2);
    waitn(2);
    wr(A_FLAG, 32'h1);
    rdreg(A_FLAG, rd); check("R9 plain clear", rd, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule